// File: doc/BRIEF.md
# Hashed-Row Packet Classifier

This block sorts IPv4 packet headers against a rule set kept in a small row-organised table. A lookup hashes the upper bits of the source address to choose a single row. It reads every rule slot of that row in parallel and tests each slot against the header. Each slot tests its two addresses as prefixes, its two ports as inclusive ranges, and its protocol as an exact value. Among the slots that hit, the one with the largest stored priority wins. The block reports that slot's rule ID, priority and action flag.

A host loads rules one slot at a time through a write port addressed by row and slot. Software must place each rule in the row that the hash picks for the rule's source prefix. Each result comes back a fixed two cycles after its request, so a network processor can issue one lookup per cycle.

Top module: `pc_classify`

## Requirements
- R1: The row read for a lookup is the XOR fold of the top HASH_PFX source-address bits. Taking those bits as a key whose least significant bit is address bit 32-HASH_PFX, key bit i is folded into row-index bit i mod ROW_AW. Rules in any other row are never considered.
- R2: An address field with length n in 1..32 matches when the top n bits of the header address equal the top n bits of the stored prefix. A length of 0 matches every address. This applies to both source and destination.
- R3: A port field matches when low <= port <= high, with both bounds inclusive. This applies to both source and destination ports.
- R4: The protocol field matches only when it is exactly equal to the header protocol.
- R5: A slot whose valid bit is 0 never matches. After reset every slot is invalid.
- R6: When several slots match, the slot with the highest stored priority wins. If priorities tie, the lowest slot index wins.
- R7: On a hit, res_rid, res_pri and res_act carry the winning slot's rule ID, priority and action flag.
- R8: res_valid pulses high for one cycle, exactly two clock cycles after each accepted lookup request.
- R9: When no slot matches, res_no_match is high with res_valid, and res_rid, res_pri and res_act are all zero. res_no_match is never high without res_valid.
- R10: When wr_en and lk_req are high in the same cycle, the write is performed and the lookup is dropped, so no res_valid follows it.
- R11: A write replaces the whole slot at (wr_row, wr_slot). wr_rule is laid out from MSB to LSB as: valid(1), src prefix(32), src length(6), dst prefix(32), dst length(6), src port low(16), src port high(16), dst port low(16), dst port high(16), protocol(8), rule ID(8), priority(4), action(1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host slot write strobe |
| wr_row | input | ROW_AW | Row being written |
| wr_slot | input | $clog2(SLOTS) | Slot being written |
| wr_rule | input | 162 | Packed rule image (layout in R11) |
| lk_req | input | 1 | Lookup request |
| lk_src | input | 32 | Header source address |
| lk_dst | input | 32 | Header destination address |
| lk_sport | input | 16 | Header source port |
| lk_dport | input | 16 | Header destination port |
| lk_proto | input | 8 | Header protocol |
| res_valid | output | 1 | Result strobe |
| res_no_match | output | 1 | No slot matched |
| res_rid | output | 8 | Winning rule ID |
| res_pri | output | 4 | Winning priority |
| res_act | output | 1 | Winning action flag |

## Verification
A host write and a lookup request can land on the same clock edge. That edge must perform the write and drop the lookup. The bench raises both strobes on one cycle, using a header that already matches a stored rule, while the write installs a stronger rule for that header. The check then requires that no result strobe appears two cycles later. A follow-up lookup with the same header must return the newly written rule, which shows that the write took effect.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int ADDR_W  = 32;
  localparam int LEN_W   = 6;
  localparam int PORT_W  = 16;
  localparam int PROTO_W = 8;
  localparam int RID_W   = 8;
  localparam int PRI_W   = 4;

  typedef struct packed {
    logic               vld;
    logic [ADDR_W-1:0]  sa;
    logic [LEN_W-1:0]   sa_len;
    logic [ADDR_W-1:0]  da;
    logic [LEN_W-1:0]   da_len;
    logic [PORT_W-1:0]  sp_lo;
    logic [PORT_W-1:0]  sp_hi;
    logic [PORT_W-1:0]  dp_lo;
    logic [PORT_W-1:0]  dp_hi;
    logic [PROTO_W-1:0] proto;
    logic [RID_W-1:0]   rid;
    logic [PRI_W-1:0]   pri;
    logic               act;
  } pc_rule_t;

  localparam int RULE_W = $bits(pc_rule_t);

  // Prefix compare: top len bits of a and p must agree; len 0 is a wildcard.
  function automatic logic pfx_hit(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] p,
                                   input logic [LEN_W-1:0]  len);
    logic [ADDR_W-1:0] m;
    if (len == '0)            m = '0;
    else if (len >= LEN_W'(ADDR_W)) m = '1;
    else                      m = ~({ADDR_W{1'b1}} >> len);
    return ((a ^ p) & m) == '0;
  endfunction

  function automatic logic in_span(input logic [PORT_W-1:0] v,
                                   input logic [PORT_W-1:0] lo,
                                   input logic [PORT_W-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // XOR fold of the top npfx address bits into an aw-bit row index.
  function automatic logic [15:0] row_hash(input logic [ADDR_W-1:0] a,
                                           input int npfx, input int aw);
    logic [15:0] h;
    h = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i >= ADDR_W - npfx) h[(i - (ADDR_W - npfx)) % aw] ^= a[i];
    end
    return h;
  endfunction
endpackage

// File: rtl/pc_row_mem.sv
module pc_row_mem #(
  parameter int ROW_AW = 3,
  parameter int SLOTS  = 4,
  localparam int ROWS    = 1 << ROW_AW,
  localparam int SLOT_AW = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ROW_AW-1:0]       wr_row,
  input  logic [SLOT_AW-1:0]      wr_slot,
  input  pc_pkg::pc_rule_t        wr_rule,
  input  logic                    rd_en,
  input  logic [ROW_AW-1:0]       rd_row,
  output pc_pkg::pc_rule_t        rd_q [SLOTS]
);
  localparam int BODY_W = pc_pkg::RULE_W - 1;

  logic [BODY_W-1:0] body [ROWS][SLOTS];
  logic [SLOTS-1:0]  vld  [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) body[wr_row][wr_slot] <= wr_rule[BODY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) vld[r] <= '0;
    end else if (wr_en) begin
      vld[wr_row][wr_slot] <= wr_rule.vld;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rd_en) rd_q[s] <= {vld[rd_row][s], body[rd_row][s]};
    end
  end
endmodule

// File: rtl/pc_slot_match.sv
module pc_slot_match (
  input  logic                         en,
  input  logic                         vld,
  input  logic [pc_pkg::ADDR_W-1:0]    sa,
  input  logic [pc_pkg::LEN_W-1:0]     sa_len,
  input  logic [pc_pkg::ADDR_W-1:0]    da,
  input  logic [pc_pkg::LEN_W-1:0]     da_len,
  input  logic [pc_pkg::PORT_W-1:0]    sp_lo,
  input  logic [pc_pkg::PORT_W-1:0]    sp_hi,
  input  logic [pc_pkg::PORT_W-1:0]    dp_lo,
  input  logic [pc_pkg::PORT_W-1:0]    dp_hi,
  input  logic [pc_pkg::PROTO_W-1:0]   proto,
  input  logic [pc_pkg::ADDR_W-1:0]    h_src,
  input  logic [pc_pkg::ADDR_W-1:0]    h_dst,
  input  logic [pc_pkg::PORT_W-1:0]    h_sport,
  input  logic [pc_pkg::PORT_W-1:0]    h_dport,
  input  logic [pc_pkg::PROTO_W-1:0]   h_proto,
  output logic                         hit
);
  import pc_pkg::*;
  logic src_ok, dst_ok, sp_ok, dp_ok, pr_ok;

  assign src_ok = pfx_hit(h_src, sa, sa_len);
  assign dst_ok = pfx_hit(h_dst, da, da_len);
  assign sp_ok  = in_span(h_sport, sp_lo, sp_hi);
  assign dp_ok  = in_span(h_dport, dp_lo, dp_hi);
  assign pr_ok  = (h_proto == proto);
  assign hit    = en && vld && src_ok && dst_ok && sp_ok && dp_ok && pr_ok;
endmodule

// File: rtl/pc_prio_sel.sv
module pc_prio_sel #(
  parameter int SLOTS = 4,
  localparam int SLOT_AW = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0]                    hit,
  input  logic [SLOTS-1:0][pc_pkg::PRI_W-1:0] pri,
  output logic                                any_hit,
  output logic [SLOT_AW-1:0]                  win_idx,
  output logic [SLOTS-1:0]                    win_oh
);
  logic [pc_pkg::PRI_W-1:0] best;

  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    best    = '0;
    for (int s = 0; s < SLOTS; s++) begin
      // strict compare keeps the lower index on a tie
      if (hit[s] && (!any_hit || pri[s] > best)) begin
        any_hit = 1'b1;
        best    = pri[s];
        win_idx = SLOT_AW'(s);
      end
    end
    win_oh = any_hit ? (SLOTS'(1) << win_idx) : '0;
  end
endmodule

// File: rtl/pc_classify.sv
module pc_classify #(
  parameter int ROW_AW   = 3,
  parameter int SLOTS    = 4,
  parameter int HASH_PFX = 8,
  localparam int SLOT_AW = $clog2(SLOTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ROW_AW-1:0]             wr_row,
  input  logic [SLOT_AW-1:0]            wr_slot,
  input  logic [pc_pkg::RULE_W-1:0]     wr_rule,
  input  logic                          lk_req,
  input  logic [pc_pkg::ADDR_W-1:0]     lk_src,
  input  logic [pc_pkg::ADDR_W-1:0]     lk_dst,
  input  logic [pc_pkg::PORT_W-1:0]     lk_sport,
  input  logic [pc_pkg::PORT_W-1:0]     lk_dport,
  input  logic [pc_pkg::PROTO_W-1:0]    lk_proto,
  output logic                          res_valid,
  output logic                          res_no_match,
  output logic [pc_pkg::RID_W-1:0]      res_rid,
  output logic [pc_pkg::PRI_W-1:0]      res_pri,
  output logic                          res_act
);
  import pc_pkg::*;

  // named internal events for the checker
  logic                      lk_take;
  logic [ROW_AW-1:0]         lk_row;
  logic [SLOTS-1:0]          hit_vec;
  logic [SLOTS-1:0]          win_oh;
  logic                      any_hit;
  logic [SLOT_AW-1:0]        win_idx;

  logic                      s1_v;
  logic [ADDR_W-1:0]         s1_src, s1_dst;
  logic [PORT_W-1:0]         s1_sport, s1_dport;
  logic [PROTO_W-1:0]        s1_proto;
  pc_rule_t                  row_q [SLOTS];
  logic [SLOTS-1:0][PRI_W-1:0] pri_vec;

  assign lk_take = lk_req && !wr_en;   // host write wins the cycle
  assign lk_row  = ROW_AW'(row_hash(lk_src, HASH_PFX, ROW_AW));

  pc_row_mem #(.ROW_AW(ROW_AW), .SLOTS(SLOTS)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_row  (wr_row),
    .wr_slot (wr_slot),
    .wr_rule (pc_rule_t'(wr_rule)),
    .rd_en   (lk_take),
    .rd_row  (lk_row),
    .rd_q    (row_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
    end else begin
      s1_v <= lk_take;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_take) begin
      s1_src   <= lk_src;
      s1_dst   <= lk_dst;
      s1_sport <= lk_sport;
      s1_dport <= lk_dport;
      s1_proto <= lk_proto;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    pc_slot_match u_match (
      .en      (s1_v),
      .vld     (row_q[s].vld),
      .sa      (row_q[s].sa),
      .sa_len  (row_q[s].sa_len),
      .da      (row_q[s].da),
      .da_len  (row_q[s].da_len),
      .sp_lo   (row_q[s].sp_lo),
      .sp_hi   (row_q[s].sp_hi),
      .dp_lo   (row_q[s].dp_lo),
      .dp_hi   (row_q[s].dp_hi),
      .proto   (row_q[s].proto),
      .h_src   (s1_src),
      .h_dst   (s1_dst),
      .h_sport (s1_sport),
      .h_dport (s1_dport),
      .h_proto (s1_proto),
      .hit     (hit_vec[s])
    );
    assign pri_vec[s] = row_q[s].pri;
  end

  pc_prio_sel #(.SLOTS(SLOTS)) u_sel (
    .hit     (hit_vec),
    .pri     (pri_vec),
    .any_hit (any_hit),
    .win_idx (win_idx),
    .win_oh  (win_oh)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_no_match <= 1'b0;
      res_rid      <= '0;
      res_pri      <= '0;
      res_act      <= 1'b0;
    end else begin
      res_valid    <= s1_v;
      res_no_match <= s1_v && !any_hit;
      if (s1_v) begin
        res_rid <= any_hit ? row_q[win_idx].rid : '0;
        res_pri <= any_hit ? row_q[win_idx].pri : '0;
        res_act <= any_hit && row_q[win_idx].act;
      end
    end
  end
endmodule

// File: rtl/pc_classify_chk.sv
module pc_classify_chk #(
  parameter int SLOTS = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       lk_req,
  input logic                       wr_en,
  input logic                       res_valid,
  input logic                       res_no_match,
  input logic [pc_pkg::RID_W-1:0]   res_rid,
  input logic [pc_pkg::PRI_W-1:0]   res_pri,
  input logic                       res_act,
  input logic [SLOTS-1:0]           hit_vec,
  input logic [SLOTS-1:0]           win_oh
);
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !wr_en) |-> ##2 res_valid);

  p_drop_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && wr_en) |-> ##2 !res_valid);

  p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_no_match) |-> (res_rid == '0 && res_pri == '0 && !res_act));

  p_miss_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_no_match);

  p_miss_iff_nohit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_no_match == ($past(hit_vec) == '0)));

  p_single_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh));

  p_win_is_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_oh & ~hit_vec) == '0);

  p_hit_has_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |-> (win_oh != '0));
endmodule

bind pc_classify pc_classify_chk #(.SLOTS(SLOTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_req       (lk_req),
  .wr_en        (wr_en),
  .res_valid    (res_valid),
  .res_no_match (res_no_match),
  .res_rid      (res_rid),
  .res_pri      (res_pri),
  .res_act      (res_act),
  .hit_vec      (hit_vec),
  .win_oh       (win_oh)
);

// File: tb/pc_classify_bench.sv
`timescale 1ns/1ps
module pc_classify_bench;
  import pc_pkg::*;
  localparam int RAW  = 3;
  localparam int NS   = 4;
  localparam int HPFX = 8;
  localparam int NR   = 1 << RAW;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, lk_req = 0;
  logic [RAW-1:0] wr_row = '0;
  logic [1:0] wr_slot = '0;
  logic [RULE_W-1:0] wr_rule = '0;
  logic [31:0] lk_src = '0, lk_dst = '0;
  logic [15:0] lk_sport = '0, lk_dport = '0;
  logic [7:0] lk_proto = '0;
  logic res_valid, res_no_match, res_act;
  logic [7:0] res_rid;
  logic [3:0] res_pri;

  pc_classify #(.ROW_AW(RAW), .SLOTS(NS), .HASH_PFX(HPFX)) u_pc_classify (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_slot(wr_slot),
    .wr_rule(wr_rule), .lk_req(lk_req), .lk_src(lk_src), .lk_dst(lk_dst),
    .lk_sport(lk_sport), .lk_dport(lk_dport), .lk_proto(lk_proto),
    .res_valid(res_valid), .res_no_match(res_no_match), .res_rid(res_rid),
    .res_pri(res_pri), .res_act(res_act));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  pc_rule_t mdl [NR][NS];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [RAW-1:0] ref_hash(input logic [31:0] a);
    logic [31:0] key = a >> (32 - HPFX);
    logic [RAW-1:0] h = '0;
    for (int c = 0; c < HPFX; c += RAW) h ^= RAW'((key >> c) & ((1 << RAW) - 1));
    return h;
  endfunction

  function automatic bit ref_pfx(input logic [31:0] a, input logic [31:0] p, input int len);
    if (len == 0) return 1;
    if (len >= 32) return a == p;
    return (a >> (32 - len)) == (p >> (32 - len));
  endfunction

  // expected {no_match, rid, pri, act}
  function automatic logic [13:0] ref_look(input logic [31:0] s, input logic [31:0] d,
                                           input logic [15:0] sp, input logic [15:0] dp,
                                           input logic [7:0] pr);
    int r = int'(ref_hash(s));
    int best = -1;
    for (int k = 0; k < NS; k++) begin
      pc_rule_t q = mdl[r][k];
      bit m = q.vld && ref_pfx(s, q.sa, int'(q.sa_len)) && ref_pfx(d, q.da, int'(q.da_len))
              && sp >= q.sp_lo && sp <= q.sp_hi && dp >= q.dp_lo && dp <= q.dp_hi
              && pr == q.proto;
      if (m && (best < 0 || q.pri > mdl[r][best].pri)) best = k;
    end
    if (best < 0) return {1'b1, 13'd0};
    return {1'b0, mdl[r][best].rid, mdl[r][best].pri, mdl[r][best].act};
  endfunction

  task automatic put(input int row, input int slot, input pc_rule_t q);
    @(negedge clk);
    wr_en = 1; wr_row = RAW'(row); wr_slot = 2'(slot); wr_rule = q;
    @(posedge clk); #1 wr_en = 0;
    mdl[row][slot] = q;
  endtask

  task automatic look(input string req, input logic [31:0] s, input logic [31:0] d,
                      input logic [15:0] sp, input logic [15:0] dp, input logic [7:0] pr);
    logic [13:0] e = ref_look(s, d, sp, dp, pr);
    @(negedge clk);
    lk_req = 1; lk_src = s; lk_dst = d; lk_sport = sp; lk_dport = dp; lk_proto = pr;
    @(posedge clk); #1 lk_req = 0;
    @(negedge clk);
    check(res_valid == 0, "R8 early", 64'(res_valid), 0);
    @(negedge clk);
    check(res_valid == 1, "R8 strobe", 64'(res_valid), 1);
    check({res_no_match, res_rid, res_pri, res_act} == e, req,
          64'({res_no_match, res_rid, res_pri, res_act}), 64'(e));
    @(negedge clk);
    check(res_valid == 0, "R8 single pulse", 64'(res_valid), 0);
  endtask

  function automatic pc_rule_t mk(input bit v, input logic [31:0] sa, input int sl,
                                  input logic [31:0] da, input int dl,
                                  input logic [15:0] spl, input logic [15:0] sph,
                                  input logic [15:0] dpl, input logic [15:0] dph,
                                  input logic [7:0] pr, input logic [7:0] rid,
                                  input logic [3:0] pri, input bit act);
    pc_rule_t q;
    q.vld = v; q.sa = sa; q.sa_len = 6'(sl); q.da = da; q.da_len = 6'(dl);
    q.sp_lo = spl; q.sp_hi = sph; q.dp_lo = dpl; q.dp_hi = dph;
    q.proto = pr; q.rid = rid; q.pri = pri; q.act = act;
    return q;
  endfunction

  initial begin
    for (int r = 0; r < NR; r++) for (int k = 0; k < NS; k++) mdl[r][k] = '0;
    repeat (3) @(negedge clk);
    check(res_valid == 0 && res_no_match == 0, "R5 reset outputs",
          64'({res_valid, res_no_match}), 0);
    rst_n = 1;
    // R5: empty table after reset, any header misses
    look("R5 empty after reset", 32'h0A000001, 32'h01020304, 80, 443, 6);

    // R1: wildcard rule in the wrong row is not seen; in the right row it is
    begin
      logic [31:0] s = 32'hC0A80001;
      int hr = int'(ref_hash(s));
      put((hr + 1) % NR, 0, mk(1, 0, 0, 0, 0, 0, 16'hFFFF, 0, 16'hFFFF, 17, 8'h11, 3, 1));
      look("R1 other row ignored", s, 32'h0, 5, 5, 17);
      put(hr, 2, mk(1, 0, 0, 0, 0, 0, 16'hFFFF, 0, 16'hFFFF, 17, 8'h22, 5, 0));
      look("R1 hashed row used", s, 32'h0, 5, 5, 17);
      for (int t = 0; t < 32; t++) look("R1 hash sweep", {3'(t), 5'(t * 7), 24'h123456}, 0, 5, 5, 17);
      put(hr, 2, '0);
      put((hr + 1) % NR, 0, '0);
    end

    // R2: prefix length sweep on source and on destination
    begin
      logic [31:0] p = 32'hA5C33C5A;
      int hr = int'(ref_hash(p));
      for (int l = 0; l <= 32; l++) begin
        put(hr, 0, mk(1, p, l, 0, 0, 0, 16'hFFFF, 0, 16'hFFFF, 6, 8'(l), 7, l[0]));
        look("R2 src exact", p, 32'h9, 1, 1, 6);
        if (l < 32) look("R2 src bit past prefix", p ^ (32'h1 << (31 - l)), 32'h9, 1, 1, 6);
        if (l > 0)  look("R2 src bit inside prefix", p ^ (32'h1 << (32 - l)), 32'h9, 1, 1, 6);
      end
      for (int l = 0; l <= 32; l++) begin
        put(hr, 0, mk(1, 0, 0, p, l, 0, 16'hFFFF, 0, 16'hFFFF, 6, 8'(l + 64), 2, 1));
        look("R2 dst exact", p, p, 1, 1, 6);
        if (l < 32) look("R2 dst bit past prefix", p, p ^ (32'h1 << (31 - l)), 1, 1, 6);
        if (l > 0)  look("R2 dst bit inside prefix", p, p ^ (32'h1 << (32 - l)), 1, 1, 6);
      end

      // R3 port ranges, R4 protocol
      put(hr, 0, mk(1, 0, 0, 0, 0, 100, 200, 1000, 1000, 50, 8'h33, 9, 1));
      for (int v = 98; v <= 202; v++) look("R3 src port range", p, 0, 16'(v), 1000, 50);
      for (int v = 998; v <= 1002; v++) look("R3 dst port single", p, 0, 150, 16'(v), 50);
      for (int v = 48; v <= 52; v++) look("R4 protocol exact", p, 0, 150, 1000, 8'(v));

      // R5: invalid slot with matching content never hits
      put(hr, 0, mk(0, 0, 0, 0, 0, 0, 16'hFFFF, 0, 16'hFFFF, 50, 8'h44, 15, 1));
      look("R5 invalid slot", p, 0, 150, 1000, 50);

      // R6/R7: priority sweep across all four slots, ties included
      for (int c = 0; c < 256; c++) begin
        for (int k = 0; k < NS; k++)
          put(hr, k, mk(1, 0, 0, 0, 0, 0, 16'hFFFF, 0, 16'hFFFF, 50,
                        8'(k * 16 + c % 16), 4'(((c >> (2 * k)) & 3) * 5), k[0]));
        look("R6 R7 priority select", p, 0, 150, 1000, 50);
      end

      // R11: overwrite replaces the whole slot
      for (int k = 1; k < NS; k++) put(hr, k, '0);
      put(hr, 0, mk(1, 0, 0, 0, 0, 0, 16'hFFFF, 0, 16'hFFFF, 60, 8'h55, 1, 0));
      look("R11 old protocol gone", p, 0, 150, 1000, 50);
      look("R11 new protocol used", p, 0, 150, 1000, 60);
      look("R9 miss fields zero", p, 0, 150, 1000, 61);

      // R10: write and lookup on the same edge
      @(negedge clk);
      wr_en = 1; wr_row = RAW'(hr); wr_slot = 1;
      wr_rule = mk(1, 0, 0, 0, 0, 0, 16'hFFFF, 0, 16'hFFFF, 60, 8'h66, 12, 1);
      lk_req = 1; lk_src = p; lk_dst = 0; lk_sport = 150; lk_dport = 1000; lk_proto = 60;
      @(posedge clk); #1 wr_en = 0; lk_req = 0;
      mdl[hr][1] = mk(1, 0, 0, 0, 0, 0, 16'hFFFF, 0, 16'hFFFF, 60, 8'h66, 12, 1);
      @(negedge clk);
      @(negedge clk);
      check(res_valid == 0, "R10 colliding lookup dropped", 64'(res_valid), 0);
      look("R10 write took effect", p, 0, 150, 1000, 60);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule